// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block moves data words from a producer clocked by one clock to a consumer clocked by another, unrelated clock. Each side has its own active-low asynchronous reset. The producer presents a word with a write enable and watches a full flag. The consumer raises a read enable and receives the next word on a registered data output, while an empty flag tells it whether anything is waiting.

Each side keeps its own position as a binary counter. The counter is one bit wider than the storage address, so a completely full buffer can be told apart from an empty one. A registered Gray-coded copy of each counter is the only state that crosses into the other clock domain. It passes through a two-flop synchronizer there. Because consecutive Gray values differ in a single bit, a sample taken in the middle of a change still resolves to either the old position or the new one.

Both flags are formed by comparing Gray values directly, with no decode back to binary. Because of the synchronizer lag, each flag is conservative in the safe direction. Full can stay raised after the consumer has already freed space. Empty can stay raised after the producer has already added data. Neither lag can cause an overflow or an underflow.

Top module: `gray_xclk_fifo`

## Requirements
- R1: While either reset is held low and immediately after both are released, empty reads 1, full reads 0 and the read data output is 0.
- R2: Words leave the read side in exactly the order in which the write side accepted them. A write is accepted on a rising write-clock edge where the write enable is 1 and full is 0. A read is accepted on a rising read-clock edge where the read enable is 1 and empty is 0.
- R3: With no reads, exactly 2^AW writes (16 at default) are accepted before full asserts. Full stays asserted until reads free space.
- R4: A write attempted while full changes neither the write position nor the stored contents. The words later read out are exactly those accepted before full.
- R5: A read attempted while empty leaves the read position and the read data output unchanged.
- R6: The Gray-coded position that crosses each domain boundary is held in a flip-flop, and it changes by at most one bit per clock of its own domain.
- R7: The positions wrap from their maximum value back to zero. Ordering is preserved across any number of wraps.
- R8: The read data output is registered and changes only on the read-clock edge that follows an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRstN | input | 1 | Write-side asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | DW | Word to store |
| wrFull | output | 1 | Buffer full as seen from the write side |
| rdClk | input | 1 | Read-side clock |
| rdRstN | input | 1 | Read-side asynchronous reset, active low |
| rdEn | input | 1 | Read request |
| rdData | output | DW | Registered word from the last accepted read |
| rdEmpty | output | 1 | Buffer empty as seen from the read side |

## Verification
On every clock, the assertions confirm four things: the crossing Gray positions move by at most one bit, a refused write or read leaves its counter untouched, and the read data register holds still unless a read was accepted. Only the bench's scenarios can show that the accepted-write count reaches exactly the depth before full, that the word stream keeps its order through several pointer wraps, and that words offered while full never appear. For these, the bench uses a fill-then-drain run and a sweep of write and read request rates under two unrelated clock periods.

// File: rtl/gxf_pkg.sv
package gxf_pkg;
  typedef struct packed {
    logic push;   // accepted write, write-clock domain
    logic pop;    // accepted read, read-clock domain
  } gxfStrobe_t;
endpackage

// File: rtl/gxf_sync.sv
module gxf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gxf_ctrl.sv
module gxf_ctrl
  import gxf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEn,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output logic          wrFull,
  output logic          rdEmpty,
  output gxfStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wrBin, wrBinNext, wrGray, wrGrayInRd;
  logic [PW-1:0] rdBin, rdBinNext, rdGray, rdGrayInWr;

  // write side: binary count, registered Gray copy
  assign wrFull    = (wrGray == {~rdGrayInWr[PW-1:PW-2], rdGrayInWr[PW-3:0]});
  assign strobe.push = wrEn && !wrFull;
  assign wrBinNext = wrBin + PW'(strobe.push);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  // read side: binary count, registered Gray copy
  assign rdEmpty   = (rdGray == wrGrayInRd);
  assign strobe.pop = rdEn && !rdEmpty;
  assign rdBinNext = rdBin + PW'(strobe.pop);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  gxf_sync #(.W(PW)) u_wr2rd (
    .clk (rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGrayInRd)
  );
  gxf_sync #(.W(PW)) u_rd2wr (
    .clk (wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGrayInWr)
  );

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];

  // R6: crossing Gray values move one bit at a time
  a_r6_wr_gray_unit: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  a_r6_rd_gray_unit: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  // R4: refused write leaves the write position alone
  a_r4_no_overflow: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && wrFull) |=> $stable(wrBin));
  // R5: refused read leaves the read position alone
  a_r5_no_underflow: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && rdEmpty) |=> $stable(rdBin));
endmodule

// File: rtl/gxf_store.sv
module gxf_store
  import gxf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  gxfStrobe_t    strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

  // R8: output register only moves after an accepted read
  a_r8_rddata_hold: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/gray_xclk_fifo.sv
module gray_xclk_fifo
  import gxf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          wrFull,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          rdEmpty
);
  gxfStrobe_t    strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  gxf_ctrl #(.AW(AW)) u_ctrl (
    .wrClk (wrClk), .wrRstN(wrRstN), .wrEn(wrEn),
    .rdClk (rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .wrFull(wrFull), .rdEmpty(rdEmpty), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  gxf_store #(.AW(AW), .DW(DW)) u_store (
    .wrClk (wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/gray_xclk_fifo_tb.sv
module gray_xclk_fifo_tb;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 13;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PER_RUN = 60;

  logic          wrClk = 0, rdClk = 0;
  logic          wrRstN = 0, rdRstN = 0;
  logic          wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          wrFull, rdEmpty;

  int nChecks = 0, nFails = 0, nRead = 0;
  bit finished = 0;
  logic [DW-1:0] model [$];

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2.0) rdClk = ~rdClk;

  gray_xclk_fifo #(.AW(AW), .DW(DW)) u_dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writer(input int n, input int rate);
    int sent = 0;
    while (sent < n) begin
      @(negedge wrClk);
      wrEn   = (($urandom % 4) < rate);
      wrData = DW'($urandom);
      if (wrEn && !wrFull) begin
        model.push_back(wrData);
        sent++;
      end
    end
    @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic reader(input int n, input int rate);
    int got = 0;
    bit pending = 0;
    logic [DW-1:0] expect_v = '0;
    logic [DW-1:0] last = rdData;
    while (got < n || pending) begin
      @(negedge rdClk);
      if (pending) begin
        // R2 order; R7 once positions have wrapped
        if (nRead > 2*DEPTH) check(rdData == expect_v, "R7", rdData, expect_v);
        else                 check(rdData == expect_v, "R2", rdData, expect_v);
        pending = 0;
      end else begin
        check(rdData == last, "R8", rdData, last);
      end
      last = rdData;
      rdEn = (got < n) && (($urandom % 4) < rate);
      if (rdEn && !rdEmpty) begin
        if (model.size() == 0) begin
          check(0, "R5", 1, 0);
        end else begin
          expect_v = model.pop_front();
          pending = 1;
          got++;
          nRead++;
        end
      end
    end
    rdEn = 0;
  endtask

  initial begin
    int rates [4][2] = '{'{4, 4}, '{4, 1}, '{1, 4}, '{2, 3}};
    int accepted;
    logic [DW-1:0] held;
    // R1: reset values
    repeat (4) @(negedge wrClk);
    check(rdEmpty == 1, "R1", rdEmpty, 1);
    check(wrFull == 0, "R1", wrFull, 0);
    wrRstN = 1;
    rdRstN = 1;
    repeat (3) @(negedge rdClk);
    check(rdEmpty == 1, "R1", rdEmpty, 1);
    check(wrFull == 0, "R1", wrFull, 0);
    check(rdData == 0, "R1", rdData, 0);

    // R3/R4: fill with no reads, keep pushing past full
    accepted = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      @(negedge wrClk);
      wrEn   = 1;
      wrData = DW'(i + 100);
      if (!wrFull) begin
        model.push_back(wrData);
        accepted++;
      end
    end
    @(negedge wrClk);
    wrEn = 0;
    check(accepted == DEPTH, "R3", accepted, DEPTH);
    check(wrFull == 1, "R3", wrFull, 1);
    repeat (5) @(negedge wrClk);
    check(wrFull == 1, "R3", wrFull, 1);

    // drain: words match the accepted ones only (R4)
    repeat (4) @(negedge rdClk);
    reader(DEPTH, 4);
    check(model.size() == 0, "R4", model.size(), 0);
    repeat (3) @(negedge rdClk);
    check(rdEmpty == 1, "R5", rdEmpty, 1);
    repeat (5) @(negedge wrClk);
    check(wrFull == 0, "R3", wrFull, 0);

    // R5: reads while empty leave data untouched
    held = rdData;
    for (int i = 0; i < 5; i++) begin
      @(negedge rdClk);
      rdEn = 1;
      @(negedge rdClk);
      check(rdData == held, "R5", rdData, held);
      check(rdEmpty == 1, "R5", rdEmpty, 1);
    end
    rdEn = 0;

    // sweep of request rates with unrelated clocks; many wraps (R7)
    for (int r = 0; r < 4; r++) begin
      fork
        writer(PER_RUN, rates[r][0]);
        reader(PER_RUN, rates[r][1]);
      join
    end
    check(model.size() == 0, "R2", model.size(), 0);
    repeat (4) @(negedge rdClk);
    check(rdEmpty == 1, "R1", rdEmpty, 1);
    check(wrFull == 0, "R3", wrFull, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(WR_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule